// File: doc/BRIEF.md
# External Interrupt Request Aggregator

This block gathers a bank of independent external interrupt lines and presents them to a processor core as a single maskable request on one fixed architectural vector. A rising edge on any source line is captured in a pending register, so a pulse only one clock wide is still recorded. A software-written per-source enable mask decides which pending bits may take part. The processor's global interrupt-enable bit gates the whole aggregate: while it is clear, no request reaches the core.

Alongside the request, the block names the source to service. It picks the lowest-numbered pending bit that is also enabled and turns bit n into the extended vector number 32+n. Software acknowledges a source by writing ones to the pending register; each one clears its bit. If the core acknowledges the aggregate vector and nothing enabled is pending, the block raises a spurious flag. This can happen when a clear races the core's entry. All outputs come from registers and change one clock after the state that drives them.

Top module: `ext_irq_agg`

## Requirements
- R1: Each of the 32 source lines `src_i[n]` that is 0 in one cycle and 1 in the next sets pending bit n. `req_o[n]` reads 1 from the clock edge that samples the 1 onwards.
- R2: When `clr_wr_i` is 1, each pending bit whose `clr_wdata_i` bit is 1 is cleared at that edge. A rising edge on the same source in the same cycle wins, and the bit stays set.
- R3: When `en_wr_i` is 1, the enable mask `en_o` takes the value of `en_wdata_i` at that edge. Otherwise it holds its value.
- R4: When `gie_i` is 0 in a cycle, `irq_o` and `src_valid_o` are 0 in the next cycle, whatever is pending.
- R5: When `gie_i` is 1 and `req_o & en_o` is nonzero in a cycle, `irq_o` is 1 and `irq_vec_o` is 4 in the next cycle. When `irq_o` is 0, `irq_vec_o` is 0.
- R6: `src_vec_o` reports 32+n, where n is the lowest bit index set in `req_o & en_o`, together with `src_valid_o`=1, one cycle after that state. When `src_valid_o` is 0, `src_vec_o` is 0.
- R7: A pending bit whose enable bit is 0 stays latched in `req_o` but causes neither `irq_o` nor a `src_vec_o` report.
- R8: When `ack_i` is 1 in a cycle in which `req_o & en_o` is zero, `spurious_o` is 1 in the next cycle. Otherwise `spurious_o` is 0.
- R9: A cycle with `rst` high clears every pending bit, every enable bit and every registered output at that edge.
- R10: A source held at 1 sets its pending bit only once. If the bit is cleared while the line stays high, it remains clear until the line falls and rises again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 32 | External source lines, captured on rising edges |
| gie_i | input | 1 | Processor global interrupt-enable bit |
| en_wr_i | input | 1 | Write strobe for the enable mask |
| en_wdata_i | input | 32 | New enable mask value |
| clr_wr_i | input | 1 | Write strobe for write-one-to-clear of pending bits |
| clr_wdata_i | input | 32 | Pending bits to clear |
| ack_i | input | 1 | Core acknowledges the aggregate vector |
| irq_o | output | 1 | Request to the core |
| irq_vec_o | output | 5 | Architectural vector of the request (4 while requesting) |
| src_valid_o | output | 1 | A source is reported on src_vec_o |
| src_vec_o | output | 6 | Extended vector 32+n of the selected source |
| spurious_o | output | 1 | Acknowledge arrived with nothing enabled pending |
| req_o | output | 32 | Pending register contents |
| en_o | output | 32 | Enable mask contents |

## Verification
The hardest case to reach is the spurious acknowledge. It needs an acknowledge in the same cycle that a clear or a mask change has just emptied the enabled pending set. The stimulus first drives that race by clearing the only pending source and acknowledging on the next cycle. A long random phase then mixes edges, clears, mask writes and acknowledges, so both outcomes occur many times. A second hard case is a source held high across a clear, which must not re-latch. The bench holds one line high, clears it and watches the pending bit for several cycles.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int unsigned EXT_SRC_COUNT = 32;
  localparam int unsigned EXT_VEC_BASE  = 32;
  localparam int unsigned CORE_EXT_VEC  = 4;
  localparam int unsigned CORE_VEC_W    = 5;
endpackage

// File: rtl/ext_irq_pend.sv
module ext_irq_pend #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] src_i,
  input  logic         clr_wr_i,
  input  logic [N-1:0] clr_mask_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] src_d;
  logic [N-1:0] pend_q;
  logic [N-1:0] rise;
  logic [N-1:0] clr_eff;

  // previous sample is taken during reset too, so a line high at reset is no edge
  always_ff @(posedge clk) src_d <= src_i;

  assign rise    = src_i & ~src_d;
  assign clr_eff = clr_wr_i ? clr_mask_i : '0;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~clr_eff) | rise;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/ext_irq_mask.sv
module ext_irq_mask #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] en_o
);
  logic [N-1:0] en_q;

  always_ff @(posedge clk) begin
    if (rst)       en_q <= '0;
    else if (wr_i) en_q <= wdata_i;
  end

  assign en_o = en_q;
endmodule

// File: rtl/ext_irq_pick.sv
module ext_irq_pick #(
  parameter int unsigned N  = 32,
  parameter int unsigned IW = 5
) (
  input  logic [N-1:0]  req_i,
  output logic          hit_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        hit_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/ext_irq_agg.sv
module ext_irq_agg
  import ext_irq_pkg::*;
#(
  parameter int unsigned N        = EXT_SRC_COUNT,
  parameter int unsigned VEC_BASE = EXT_VEC_BASE,
  parameter int unsigned CORE_VEC = CORE_EXT_VEC,
  parameter int unsigned CV_W     = CORE_VEC_W,
  localparam int unsigned IDX_W   = (N > 1) ? $clog2(N) : 1,
  localparam int unsigned VEC_W   = $clog2(VEC_BASE + N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     src_i,
  input  logic             gie_i,
  input  logic             en_wr_i,
  input  logic [N-1:0]     en_wdata_i,
  input  logic             clr_wr_i,
  input  logic [N-1:0]     clr_wdata_i,
  input  logic             ack_i,
  output logic             irq_o,
  output logic [CV_W-1:0]  irq_vec_o,
  output logic             src_valid_o,
  output logic [VEC_W-1:0] src_vec_o,
  output logic             spurious_o,
  output logic [N-1:0]     req_o,
  output logic [N-1:0]     en_o
);
  logic [N-1:0]     pend;
  logic [N-1:0]     en;
  logic [N-1:0]     active;
  logic             hit;
  logic [IDX_W-1:0] idx;

  ext_irq_pend #(.N(N)) u_pend (
    .clk(clk), .rst(rst), .src_i(src_i),
    .clr_wr_i(clr_wr_i), .clr_mask_i(clr_wdata_i), .pend_o(pend)
  );

  ext_irq_mask #(.N(N)) u_mask (
    .clk(clk), .rst(rst), .wr_i(en_wr_i), .wdata_i(en_wdata_i), .en_o(en)
  );

  assign active = pend & en;

  ext_irq_pick #(.N(N), .IW(IDX_W)) u_pick (
    .req_i(active), .hit_o(hit), .idx_o(idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o       <= 1'b0;
      irq_vec_o   <= '0;
      src_valid_o <= 1'b0;
      src_vec_o   <= '0;
      spurious_o  <= 1'b0;
    end else begin
      irq_o       <= gie_i & (|active);
      irq_vec_o   <= (gie_i & (|active)) ? CV_W'(CORE_VEC) : '0;
      src_valid_o <= gie_i & hit;
      src_vec_o   <= (gie_i & hit) ? VEC_W'(VEC_BASE + 32'(idx)) : '0;
      spurious_o  <= ack_i & ~hit;
    end
  end

  assign req_o = pend;
  assign en_o  = en;
endmodule

// File: rtl/ext_irq_agg_chk.sv
module ext_irq_agg_chk #(
  parameter int unsigned N        = 32,
  parameter int unsigned VEC_BASE = 32,
  parameter int unsigned CORE_VEC = 4,
  parameter int unsigned CV_W     = 5,
  parameter int unsigned VEC_W    = 6
) (
  input logic             clk,
  input logic             rst,
  input logic [N-1:0]     src_i,
  input logic             gie_i,
  input logic             clr_wr_i,
  input logic [N-1:0]     clr_wdata_i,
  input logic             ack_i,
  input logic             irq_o,
  input logic [CV_W-1:0]  irq_vec_o,
  input logic             src_valid_o,
  input logic [VEC_W-1:0] src_vec_o,
  input logic             spurious_o,
  input logic [N-1:0]     req_o,
  input logic [N-1:0]     en_o
);
  p_reset_r9: assert property (@(posedge clk)
    rst |=> (req_o == '0 && en_o == '0 && !irq_o && !src_valid_o && !spurious_o));

  p_clear_all_r2: assert property (@(posedge clk) disable iff (rst)
    (clr_wr_i && (&clr_wdata_i) && src_i == '0) |=> req_o == '0);

  p_gate_r4: assert property (@(posedge clk) disable iff (rst)
    !gie_i |=> (!irq_o && !src_valid_o));

  p_raise_r5: assert property (@(posedge clk) disable iff (rst)
    (gie_i && ((req_o & en_o) != '0)) |=> (irq_o && irq_vec_o == CV_W'(CORE_VEC)));

  p_range_r6: assert property (@(posedge clk) disable iff (rst)
    src_valid_o |-> (32'(src_vec_o) >= VEC_BASE && 32'(src_vec_o) < VEC_BASE + N));

  p_pair_r6: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> src_valid_o);

  p_masked_r7: assert property (@(posedge clk) disable iff (rst)
    ((req_o & en_o) == '0) |=> !irq_o);

  p_spur_r8: assert property (@(posedge clk) disable iff (rst)
    (ack_i && ((req_o & en_o) == '0)) |=> spurious_o);

  p_nospur_r8: assert property (@(posedge clk) disable iff (rst)
    (ack_i && ((req_o & en_o) != '0)) |=> !spurious_o);
endmodule

bind ext_irq_agg ext_irq_agg_chk #(
  .N(N), .VEC_BASE(VEC_BASE), .CORE_VEC(CORE_VEC), .CV_W(CV_W), .VEC_W(VEC_W)
) u_chk (
  .clk(clk), .rst(rst), .src_i(src_i), .gie_i(gie_i),
  .clr_wr_i(clr_wr_i), .clr_wdata_i(clr_wdata_i), .ack_i(ack_i),
  .irq_o(irq_o), .irq_vec_o(irq_vec_o), .src_valid_o(src_valid_o),
  .src_vec_o(src_vec_o), .spurious_o(spurious_o), .req_o(req_o), .en_o(en_o)
);

// File: tb/ext_irq_agg_bench.sv
module ext_irq_agg_bench;
  localparam int CLK_T = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src_i = '0;
  logic        gie_i = 1'b0;
  logic        en_wr_i = 1'b0;
  logic [31:0] en_wdata_i = '0;
  logic        clr_wr_i = 1'b0;
  logic [31:0] clr_wdata_i = '0;
  logic        ack_i = 1'b0;
  logic        irq_o;
  logic [4:0]  irq_vec_o;
  logic        src_valid_o;
  logic [5:0]  src_vec_o;
  logic        spurious_o;
  logic [31:0] req_o;
  logic [31:0] en_o;

  int checks = 0;
  int fails  = 0;
  bit started = 0;
  bit done = 0;

  ext_irq_agg u_ext_irq_agg (
    .clk(clk), .rst(rst), .src_i(src_i), .gie_i(gie_i),
    .en_wr_i(en_wr_i), .en_wdata_i(en_wdata_i),
    .clr_wr_i(clr_wr_i), .clr_wdata_i(clr_wdata_i), .ack_i(ack_i),
    .irq_o(irq_o), .irq_vec_o(irq_vec_o), .src_valid_o(src_valid_o),
    .src_vec_o(src_vec_o), .spurious_o(spurious_o), .req_o(req_o), .en_o(en_o)
  );

  always #(CLK_T/2) clk = ~clk;

  // behavioural reference
  bit [31:0] m_pend, m_en, m_prev;
  bit        m_irq, m_valid, m_spur;
  int        m_vec, m_cvec;

  always @(posedge clk) begin
    int low;
    bit [31:0] act;
    started <= 1'b1;
    if (rst) begin
      m_pend = 0; m_en = 0; m_irq = 0; m_valid = 0; m_spur = 0;
      m_vec = 0; m_cvec = 0;
    end else begin
      act = m_pend & m_en;
      low = -1;
      for (int k = 31; k >= 0; k--) if (act[k]) low = k;
      m_irq   = gie_i && (act != 0);
      m_cvec  = m_irq ? 4 : 0;
      m_valid = gie_i && (low >= 0);
      m_vec   = m_valid ? 32 + low : 0;
      m_spur  = ack_i && (act == 0);
      if (clr_wr_i) m_pend = m_pend & ~clr_wdata_i;
      m_pend = m_pend | (src_i & ~m_prev);
      if (en_wr_i) m_en = en_wdata_i;
    end
    m_prev = src_i;
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk(req_o == m_pend, "R1", "req_o", req_o, m_pend);
      chk(en_o == m_en, "R3", "en_o", en_o, m_en);
      chk(irq_o == m_irq, "R5", "irq_o", irq_o, m_irq);
      chk(int'(irq_vec_o) == m_cvec, "R5", "irq_vec_o", irq_vec_o, m_cvec);
      chk(src_valid_o == m_valid, "R6", "src_valid_o", src_valid_o, m_valid);
      chk(int'(src_vec_o) == m_vec, "R6", "src_vec_o", src_vec_o, m_vec);
      chk(spurious_o == m_spur, "R8", "spurious_o", spurious_o, m_spur);
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr_en(input bit [31:0] v);
    en_wr_i = 1; en_wdata_i = v; step(1); en_wr_i = 0;
  endtask

  task automatic wr_clr(input bit [31:0] v);
    clr_wr_i = 1; clr_wdata_i = v; step(1); clr_wr_i = 0; clr_wdata_i = '0;
  endtask

  task automatic pulse(input bit [31:0] v);
    src_i = v; step(1); src_i = '0;
  endtask

  initial begin
    step(3);
    rst = 0;
    step(1);
    // R9: reset state
    chk(req_o == 0 && en_o == 0 && !irq_o && !src_valid_o && !spurious_o,
        "R9", "reset state", {req_o, en_o}, 0);

    wr_en('1);
    gie_i = 1;
    pulse(32'h0000_0020);
    step(1);
    // R1 R5 R6: single source 5 gives vector 37
    chk(irq_o && irq_vec_o == 4, "R5", "irq on vector 4", irq_vec_o, 4);
    chk(src_vec_o == 37, "R6", "source 5 vector", src_vec_o, 37);

    pulse(32'h8000_0001);
    step(1);
    chk(src_vec_o == 32, "R6", "lowest of 0,5,31", src_vec_o, 32);
    wr_clr(32'h0000_0001);
    step(1);
    chk(src_vec_o == 37, "R2", "after clearing bit 0", src_vec_o, 37);
    wr_clr(32'h0000_0020);
    step(1);
    chk(src_vec_o == 63, "R6", "only bit 31 left", src_vec_o, 63);
    wr_clr('1);
    step(1);
    chk(req_o == 0 && !irq_o, "R2", "all cleared", req_o, 0);

    // R7: masked source stays latched, no request
    wr_en(32'h0000_0400);
    pulse(32'h0000_0008);
    step(2);
    chk(req_o == 32'h8 && !irq_o && !src_valid_o, "R7", "masked pending", {irq_o, req_o}, 32'h8);

    // R4: global disable suppresses enabled pending
    wr_en('1);
    gie_i = 0;
    step(2);
    chk(!irq_o && !src_valid_o, "R4", "gie low", irq_o, 0);
    gie_i = 1;
    step(2);
    chk(irq_o && src_vec_o == 35, "R4", "gie back high", src_vec_o, 35);

    // R8: clear races acknowledge
    clr_wr_i = 1; clr_wdata_i = 32'h8; step(1); clr_wr_i = 0;
    ack_i = 1; step(1); ack_i = 0;
    chk(spurious_o, "R8", "spurious after race", spurious_o, 1);
    step(1);
    chk(!spurious_o, "R8", "spurious drops", spurious_o, 0);

    // R10: held level does not re-latch
    src_i = 32'h80;
    step(2);
    wr_clr(32'h80);
    step(4);
    chk(req_o[7] == 0, "R10", "held high no relatch", req_o[7], 0);
    src_i = 0; step(1);
    // R2: edge and clear in same cycle, edge wins
    src_i = 32'h80; clr_wr_i = 1; clr_wdata_i = 32'h80; step(1);
    clr_wr_i = 0; src_i = 0;
    chk(req_o[7] == 1, "R2", "edge beats clear", req_o[7], 1);

    // random phase
    for (int c = 0; c < 4000; c++) begin
      src_i       = $urandom() & $urandom() & $urandom();
      gie_i       = ($urandom() % 8) != 0;
      ack_i       = ($urandom() % 4) == 0;
      clr_wr_i    = ($urandom() % 3) == 0;
      clr_wdata_i = $urandom() | $urandom();
      en_wr_i     = ($urandom() % 16) == 0;
      en_wdata_i  = $urandom();
      if (c == 2500) rst = 1;
      if (c == 2503) rst = 0;
      step(1);
    end
    src_i = 0; gie_i = 0; ack_i = 0; clr_wr_i = 0; en_wr_i = 0; rst = 0;
    step(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_T * 150000);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule